// File: doc/BRIEF.md
# Descriptor Ring Producer with Pass Stamping

This block is the writing side of a circular descriptor ring held in local storage. Each slot holds a descriptor of eight 32-bit words. A source hands over one whole descriptor per accepted push, and the block stores it at the head slot. Before the write it replaces the upper twelve bits of the last word with two fields: a ring identifier taken from a configuration input, and a four-bit pass counter.

The pass counter lets a consumer find new slots from their contents alone. Storage is zero after reset, and the first trip around the ring stamps the value 1. Each later trip stamps the next value, wrapping from 15 to 0. A consumer that polls slots therefore only compares the lowest bit of the stamp with the parity it expects for the current trip.

The consumer reads any word of any slot through a combinational read port. It frees slots by writing a new tail index. From head and tail the block derives the pending count, the empty and full flags and a level interrupt.

Top module: `ring_stamp_producer`

## Requirements
- R1: After reset the pending count is 0, `ring_empty` is 1, `ring_full` and `irq_pending` are 0, `push_ready` is 1, `loop_count` is 0 and every word of every slot reads 0.
- R2: An accepted push (`push_valid` and `push_ready` high at a rising edge) stores words 0 to 6 of `push_desc` (word k at bits [32k+31:32k]) unchanged, and bits [19:0] of word 7 unchanged, in the slot at `head_ptr`. The head then advances by one modulo DEPTH.
- R3: Bits [27:20] of word 7 of a stored slot equal `cfg_ring_id` as sampled at the accepting edge, whatever the pushed descriptor held there.
- R4: Bits [31:28] of word 7 hold the trip number modulo 16: 1 on the first trip after reset, then 2, 3 and so on. After 15 the next trip stamps 0, and the count never saturates.
- R5: `loop_count` increments by one, modulo 16, exactly when an accepted push writes slot 0, and holds otherwise. The slot written at index 0 already carries the new value.
- R6: When the pending count equals DEPTH-1, `push_ready` is 0 and `ring_full` is 1. A push offered then changes neither the head, the pending count nor any stored word.
- R7: `pending_cnt` equals (head - tail) modulo DEPTH. `ring_empty` is 1 exactly when it is 0, and `irq_pending` is 1 exactly when it is nonzero.
- R8: A pulse on `tail_wr_en` loads `tail_wr_val` as the new tail from the next cycle on, and the freed slots make room for further pushes.
- R9: `rd_data` shows word `rd_word` of slot `rd_idx` within the same cycle, with the stamp included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ring_id | input | 8 | Identifier stamped into word 7 bits [27:20] |
| push_valid | input | 1 | Descriptor offered |
| push_ready | output | 1 | Ring has room; the offer is taken at this edge |
| push_desc | input | 256 | Descriptor, word k at bits [32k+31:32k] |
| rd_idx | input | $clog2(DEPTH) | Slot to read |
| rd_word | input | 3 | Word within the slot to read |
| rd_data | output | 32 | Selected stored word |
| tail_wr_en | input | 1 | Load a new tail |
| tail_wr_val | input | $clog2(DEPTH) | New tail index |
| head_ptr | output | $clog2(DEPTH) | Next slot to be written |
| loop_count | output | 4 | Current pass counter |
| pending_cnt | output | $clog2(DEPTH) | Slots written but not yet freed |
| ring_empty | output | 1 | No pending slots |
| ring_full | output | 1 | DEPTH-1 slots pending |
| irq_pending | output | 1 | Level interrupt while slots are pending |

## Verification
The assertions assume the consumer never moves the tail past the head. Every tail value written must therefore lie in the range from the old tail up to the current head, so that a tail update can only lower the pending count. This is why the interrupt can rise only after an accepted push. The stimulus keeps to this by setting each new tail a small, known distance behind the head it has just observed, and by never pushing and moving the tail in the same cycle. The sweep runs seventeen full trips and more, changes the identifier on every trip, and fills the ring to its limit once, so that the 15-to-0 stamp wrap and the refusal at DEPTH-1 are both reached.

// File: rtl/ring_stamp_producer.sv
module ring_stamp_producer #(
  parameter int DEPTH       = 8,
  parameter int WORD_W      = 32,
  parameter int ENTRY_WORDS = 8,
  parameter int ID_W        = 8,
  parameter int LOOP_W      = 4,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int WSEL_W     = $clog2(ENTRY_WORDS),
  localparam int DESC_W     = WORD_W * ENTRY_WORDS,
  localparam int LOW_W      = WORD_W - ID_W - LOOP_W,
  localparam int STAMP_WORD = ENTRY_WORDS - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   cfg_ring_id,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DESC_W-1:0] push_desc,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data,
  input  logic              tail_wr_en,
  input  logic [IDX_W-1:0]  tail_wr_val,
  output logic [IDX_W-1:0]  head_ptr,
  output logic [LOOP_W-1:0] loop_count,
  output logic [IDX_W-1:0]  pending_cnt,
  output logic              ring_empty,
  output logic              ring_full,
  output logic              irq_pending
);

  logic [WORD_W-1:0] mem_q [DEPTH][ENTRY_WORDS];
  logic [IDX_W-1:0]  head_q, tail_q;
  logic [LOOP_W-1:0] loop_q;
  logic [LOOP_W-1:0] stamp_loop;
  logic [WORD_W-1:0] stamped_word;
  logic              fire;

  assign pending_cnt  = head_q - tail_q;
  assign ring_full    = (pending_cnt == IDX_W'(DEPTH - 1));
  assign ring_empty   = (pending_cnt == '0);
  assign irq_pending  = !ring_empty;
  assign push_ready   = !ring_full;
  assign fire         = push_valid && push_ready;
  assign head_ptr     = head_q;
  assign loop_count   = loop_q;
  assign rd_data      = mem_q[rd_idx][rd_word];

  assign stamp_loop   = (head_q == '0) ? loop_q + LOOP_W'(1) : loop_q;
  assign stamped_word = {stamp_loop, cfg_ring_id,
                         push_desc[STAMP_WORD*WORD_W +: LOW_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      loop_q <= '0;
    end else if (fire) begin
      head_q <= head_q + IDX_W'(1);
      loop_q <= stamp_loop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tail_q <= '0;
    else if (tail_wr_en) tail_q <= tail_wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        for (int j = 0; j < ENTRY_WORDS; j++)
          mem_q[i][j] <= '0;
    end else if (fire) begin
      for (int j = 0; j < ENTRY_WORDS; j++)
        mem_q[head_q][j] <= (j == STAMP_WORD) ? stamped_word
                                              : push_desc[j*WORD_W +: WORD_W];
    end
  end

endmodule

module ring_stamp_producer_chk #(
  parameter int DEPTH       = 8,
  parameter int WORD_W      = 32,
  parameter int ENTRY_WORDS = 8,
  parameter int ID_W        = 8,
  parameter int LOOP_W      = 4,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int STAMP_WORD = ENTRY_WORDS - 1,
  localparam int ID_LSB     = WORD_W - ID_W - LOOP_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_valid,
  input logic              push_ready,
  input logic [ID_W-1:0]   cfg_ring_id,
  input logic [IDX_W-1:0]  head_ptr,
  input logic [LOOP_W-1:0] loop_count,
  input logic [IDX_W-1:0]  pending_cnt,
  input logic              tail_wr_en,
  input logic              irq_pending,
  input logic [WORD_W-1:0] mem_q [DEPTH][ENTRY_WORDS]
);

  logic acc;
  assign acc = push_valid && push_ready;

  assert_head_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> head_ptr == $past(head_ptr) + IDX_W'(1));

  assert_ring_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> mem_q[$past(head_ptr)][STAMP_WORD][ID_LSB +: ID_W] == $past(cfg_ring_id));

  assert_loop_stamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> mem_q[$past(head_ptr)][STAMP_WORD][WORD_W-1 -: LOOP_W] == loop_count);

  assert_loop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && head_ptr == '0) |=> loop_count == $past(loop_count) + LOOP_W'(1));

  assert_loop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && head_ptr == '0) |=> $stable(loop_count));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> pending_cnt != IDX_W'(DEPTH - 1));

  assert_refused_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready && !tail_wr_en) |=> $stable(head_ptr) && $stable(pending_cnt));

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending) |-> $past(acc));

endmodule

bind ring_stamp_producer ring_stamp_producer_chk #(
  .DEPTH(DEPTH), .WORD_W(WORD_W), .ENTRY_WORDS(ENTRY_WORDS),
  .ID_W(ID_W), .LOOP_W(LOOP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
  .cfg_ring_id(cfg_ring_id), .head_ptr(head_ptr), .loop_count(loop_count),
  .pending_cnt(pending_cnt), .tail_wr_en(tail_wr_en), .irq_pending(irq_pending),
  .mem_q(mem_q)
);

// File: tb/ring_stamp_producer_bench.sv
module ring_stamp_producer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [7:0]   cfg_ring_id = 8'h5A;
  logic         push_valid = 0;
  logic         push_ready;
  logic [255:0] push_desc = '0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic [2:0]   rd_word = '0;
  logic [31:0]  rd_data;
  logic         tail_wr_en = 0;
  logic [IDX_W-1:0] tail_wr_val = '0;
  logic [IDX_W-1:0] head_ptr;
  logic [3:0]   loop_count;
  logic [IDX_W-1:0] pending_cnt;
  logic         ring_empty, ring_full, irq_pending;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_stamp_producer #(.DEPTH(DEPTH)) u_ring_stamp_producer (
    .clk(clk), .rst_n(rst_n), .cfg_ring_id(cfg_ring_id),
    .push_valid(push_valid), .push_ready(push_ready), .push_desc(push_desc),
    .rd_idx(rd_idx), .rd_word(rd_word), .rd_data(rd_data),
    .tail_wr_en(tail_wr_en), .tail_wr_val(tail_wr_val),
    .head_ptr(head_ptr), .loop_count(loop_count), .pending_cnt(pending_cnt),
    .ring_empty(ring_empty), .ring_full(ring_full), .irq_pending(irq_pending));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] make_desc(input int p, input int idx);
    logic [255:0] d;
    for (int w = 0; w < 8; w++)
      d[w*32 +: 32] = {8'(p * 3 + 1), 8'(idx), 8'(w), 8'hC3} ^ 32'(p * 32'h0101_0707);
    d[255:244] = 12'hFFF;
    return d;
  endfunction

  task automatic push(input logic [255:0] d);
    @(negedge clk);
    push_valid = 1;
    push_desc  = d;
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic set_tail(input logic [IDX_W-1:0] v);
    @(negedge clk);
    tail_wr_en  = 1;
    tail_wr_val = v;
    @(negedge clk);
    tail_wr_en  = 0;
  endtask

  task automatic read_word(input int idx, input int w, output logic [31:0] v);
    rd_idx  = IDX_W'(idx);
    rd_word = 3'(w);
    #1;
    v = rd_data;
  endtask

  task automatic check_slot(input string tag, input int idx, input logic [255:0] d,
                            input logic [7:0] id, input logic [3:0] lp);
    logic [31:0] v;
    for (int w = 0; w < 7; w++) begin
      read_word(idx, w, v);
      chk({tag, " R2 word"}, v, d[w*32 +: 32]);
    end
    read_word(idx, 7, v);
    chk({tag, " R2 low bits"}, {12'h0, v[19:0]}, {12'h0, d[243:224]});
    chk({tag, " R3 ring id"}, {24'h0, v[27:20]}, {24'h0, id});
    chk({tag, " R4 loop stamp"}, {28'h0, v[31:28]}, {28'h0, lp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [255:0] d;
    int exp_head;
    int exp_loop;
    int ok_zero;
    int k;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pending", 32'(pending_cnt), 0);
    chk("R1 empty", 32'(ring_empty), 1);
    chk("R1 full", 32'(ring_full), 0);
    chk("R1 irq", 32'(irq_pending), 0);
    chk("R1 ready", 32'(push_ready), 1);
    chk("R1 loop", 32'(loop_count), 0);
    ok_zero = 1;
    for (int i = 0; i < DEPTH; i++)
      for (int w = 0; w < 8; w++) begin
        read_word(i, w, v);
        if (v !== 0) ok_zero = 0;
      end
    chk("R1 storage zero", 32'(ok_zero), 1);

    // Fill to the limit on the first trip
    exp_head = 0;
    exp_loop = 0;
    for (int i = 0; i < DEPTH - 1; i++) begin
      d = make_desc(0, i);
      push(d);
      if (exp_head == 0) exp_loop = (exp_loop + 1) % 16;
      check_slot("fill", exp_head, d, 8'h5A, 4'(exp_loop));
      chk("R9 read head-1 stamp id", 32'(rd_data[27:20]), 32'h5A);
      exp_head = (exp_head + 1) % DEPTH;
      chk("R7 pending during fill", 32'(pending_cnt), 32'(i + 1));
    end
    chk("R5 loop after first trip start", 32'(loop_count), 1);
    chk("R6 full", 32'(ring_full), 1);
    chk("R6 ready low", 32'(push_ready), 0);
    chk("R7 irq", 32'(irq_pending), 1);

    // Refused push
    push(make_desc(9, 9));
    chk("R6 head held", 32'(head_ptr), 32'(DEPTH - 1));
    chk("R6 pending held", 32'(pending_cnt), 32'(DEPTH - 1));
    ok_zero = 1;
    for (int w = 0; w < 8; w++) begin
      read_word(DEPTH - 1, w, v);
      if (v !== 0) ok_zero = 0;
    end
    chk("R6 slot untouched", 32'(ok_zero), 1);

    // Free all
    set_tail(IDX_W'(DEPTH - 1));
    chk("R8 pending after tail", 32'(pending_cnt), 0);
    chk("R7 empty", 32'(ring_empty), 1);
    chk("R7 irq low", 32'(irq_pending), 0);
    chk("R8 ready again", 32'(push_ready), 1);

    // Long sweep: more than 17 trips, id changes per trip
    k = 0;
    while (exp_loop != 2 || exp_head != 1 || k < DEPTH * 17) begin
      if (exp_head == 0) exp_loop = (exp_loop + 1) % 16;
      cfg_ring_id = 8'(exp_loop * 29 + 7);
      d = make_desc(k + 1, exp_head);
      push(d);
      check_slot("sweep", exp_head, d, 8'(exp_loop * 29 + 7), 4'(exp_loop));
      chk("R5 loop count", 32'(loop_count), 32'(exp_loop));
      exp_head = (exp_head + 1) % DEPTH;
      chk("R2 head advance", 32'(head_ptr), 32'(exp_head));
      set_tail(IDX_W'((exp_head - (k % 3) + DEPTH) % DEPTH));
      chk("R7 pending", 32'(pending_cnt), 32'(k % 3));
      chk("R7 empty flag", 32'(ring_empty), 32'((k % 3) == 0));
      k++;
    end
    chk("R4 wrapped past 15", 32'(loop_count), 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule